// File: doc/BRIEF.md
# Parallel 8080-Style LCD Write-Cycle Sequencer

This block turns single write requests into parallel 8080-style bus write cycles toward an LCD panel controller. A requester offers a data word and a flag that selects a command or a data transfer. When the block is idle it accepts the request, presents the flag on the register-select line and the word on the data bus, and then steps through four timed phases. Each phase is set by its own static 8-bit count and lasts that count plus one clock. The phases are: select line to chip-select setup, chip-select to write-enable setup, write-enable active width, and write-enable to chip-select hold.

The sequencer is a five-state machine. IDLE is the only state with ready high. The transition IDLE->ADDR is taken on an accepted request. It captures the flag and the word, loads the first phase count and captures the other three counts. ADDR->CSSU is taken when the address phase expires and drives chip select low. CSSU->WRACT is taken when the setup phase expires and activates write enable and the data drivers. WRACT->HOLD is taken when the active width expires and releases write enable. HOLD->IDLE is taken when the hold phase expires. It releases chip select and the data drivers and raises a one-clock done pulse. A request already waiting at that moment is accepted on the next edge, so cycles run back to back with a single idle clock between them. An invert input flips the active level of the write-enable pin without changing any phase length.

Top module: `lcd_wcyc_seq`

## Requirements
- R1: During and directly after reset, lcd_cs_n is 1, lcd_we is at its inactive level, lcd_data_oe is 0, done is 0 and req_ready is 1.
- R2: req_ready is 1 only in IDLE, and a request is taken at an edge where req_valid and req_ready are both 1. From the next clock onward, lcd_rs equals the captured req_is_cmd (1 = command, 0 = data) and lcd_data equals the captured req_data. Both hold until the next accepted request, including while idle and while a new request waits.
- R3: lcd_cs_n stays 1 for exactly cfg_cs_setup+1 clocks after the accepting edge and then goes to 0.
- R4: After lcd_cs_n falls, write enable stays inactive for exactly cfg_wr_setup+1 clocks and then becomes active.
- R5: Write enable stays active for exactly cfg_wr_active+1 clocks.
- R6: After write enable returns inactive, lcd_cs_n stays 0 for exactly cfg_wr_hold+1 clocks and then returns to 1.
- R7: lcd_data_oe is 1 from the first clock of write-enable activity until lcd_cs_n returns to 1, and is 0 at every other time.
- R8: The four timing inputs are taken only at the accepting edge. Changing them during a cycle does not alter that cycle's phase lengths.
- R9: With we_invert=0, write enable is active when lcd_we is 0. With we_invert=1, it is active when lcd_we is 1. The inactive level is the opposite one.
- R10: done is 1 for exactly one clock, in the clock where lcd_cs_n returns to 1, and is 0 at every other time.
- R11: If req_valid is 1 when lcd_cs_n returns to 1, req_ready is 1 in that same clock and the next address phase begins on the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock; all phases are counted in its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Sequencer idle; request accepted at this edge if valid |
| req_is_cmd | input | 1 | Register-select value for the transfer (1 command, 0 data) |
| req_data | input | DW | Word to write |
| cfg_cs_setup | input | TW | Select-line to chip-select setup count |
| cfg_wr_setup | input | TW | Chip-select to write-enable setup count |
| cfg_wr_active | input | TW | Write-enable active width count |
| cfg_wr_hold | input | TW | Write-enable to chip-select hold count |
| we_invert | input | 1 | Flip the active level of lcd_we |
| lcd_rs | output | 1 | Register-select (address) line |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_we | output | 1 | Write enable, active low unless inverted |
| lcd_data | output | DW | Data bus value |
| lcd_data_oe | output | 1 | Data bus drive enable |
| done | output | 1 | One-clock pulse as chip select deasserts |

## Verification
The end-of-cycle done pulse and the acceptance of the next request can fall in the same clock. In that clock chip select rises, done is high and ready is high while a request is already waiting. The bench provokes this by offering the next request as soon as the previous one is taken, so the request waits through the whole cycle. At that clock the monitor requires done and ready both high. It then requires that the next sample is already in the new address phase and shows the new select value and word. A one-clock gap or a lost request would break the phase counts for every later queued item.

// File: rtl/lcd_wcyc_pkg.sv
package lcd_wcyc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_CSSU  = 3'd2,
        ST_WRACT = 3'd3,
        ST_HOLD  = 3'd4
    } wcyc_state_t;

    // reset values of the captured phase counts
    localparam int unsigned DEF_WR_SETUP  = 0;
    localparam int unsigned DEF_WR_ACTIVE = 1;
    localparam int unsigned DEF_WR_HOLD   = 0;

endpackage

// File: rtl/lcd_wcyc_timer.sv
module lcd_wcyc_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3: an expired counter stays expired until reloaded
    a_r3_timer_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/lcd_wcyc_fsm.sv
module lcd_wcyc_fsm
    import lcd_wcyc_pkg::*;
#(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [TW-1:0] cfg_cs_setup,
    input  logic [TW-1:0] cfg_wr_setup,
    input  logic [TW-1:0] cfg_wr_active,
    input  logic [TW-1:0] cfg_wr_hold,
    input  logic          expired,
    output wcyc_state_t   state,
    output wcyc_state_t   state_nxt,
    output logic          ready,
    output logic          accept,
    output logic          load,
    output logic [TW-1:0] load_val
);

    wcyc_state_t   state_q;
    logic [TW-1:0] wr_setup_q;
    logic [TW-1:0] wr_active_q;
    logic [TW-1:0] wr_hold_q;

    // state register and captured counts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            wr_setup_q  <= TW'(DEF_WR_SETUP);
            wr_active_q <= TW'(DEF_WR_ACTIVE);
            wr_hold_q   <= TW'(DEF_WR_HOLD);
        end else begin
            state_q <= state_nxt;
            if (accept) begin
                wr_setup_q  <= cfg_wr_setup;
                wr_active_q <= cfg_wr_active;
                wr_hold_q   <= cfg_wr_hold;
            end
        end
    end

    // next state and phase count loading
    always_comb begin
        state_nxt = state_q;
        load      = 1'b0;
        load_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_nxt = ST_ADDR;
                    load      = 1'b1;
                    load_val  = cfg_cs_setup;
                end
            end
            ST_ADDR: begin
                if (expired) begin
                    state_nxt = ST_CSSU;
                    load      = 1'b1;
                    load_val  = wr_setup_q;
                end
            end
            ST_CSSU: begin
                if (expired) begin
                    state_nxt = ST_WRACT;
                    load      = 1'b1;
                    load_val  = wr_active_q;
                end
            end
            ST_WRACT: begin
                if (expired) begin
                    state_nxt = ST_HOLD;
                    load      = 1'b1;
                    load_val  = wr_hold_q;
                end
            end
            ST_HOLD: begin
                if (expired) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    assign state  = state_q;
    assign ready  = (state_q == ST_IDLE);
    assign accept = ready && req_valid;

    // R2: leaving idle happens only through an accepted request
    a_r2_leave_idle_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req_valid) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/lcd_wcyc_pins.sv
module lcd_wcyc_pins
    import lcd_wcyc_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          req_is_cmd,
    input  logic [DW-1:0] req_data,
    input  wcyc_state_t   state,
    input  wcyc_state_t   state_nxt,
    input  logic          expired,
    input  logic          we_invert,
    output logic          lcd_rs,
    output logic          lcd_cs_n,
    output logic          lcd_we,
    output logic [DW-1:0] lcd_data,
    output logic          lcd_data_oe,
    output logic          done
);

    logic          rs_q;
    logic [DW-1:0] data_q;
    logic          cs_n_q;
    logic          we_act_q;
    logic          oe_q;
    logic          done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q     <= 1'b0;
            data_q   <= '0;
            cs_n_q   <= 1'b1;
            we_act_q <= 1'b0;
            oe_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (accept) begin
                rs_q   <= req_is_cmd;
                data_q <= req_data;
            end
            cs_n_q   <= !(state_nxt inside {ST_CSSU, ST_WRACT, ST_HOLD});
            we_act_q <= (state_nxt == ST_WRACT);
            oe_q     <= (state_nxt inside {ST_WRACT, ST_HOLD});
            done_q   <= (state == ST_HOLD) && expired;
        end
    end

    assign lcd_rs      = rs_q;
    assign lcd_data    = data_q;
    assign lcd_cs_n    = cs_n_q;
    assign lcd_we      = we_act_q ^ ~we_invert;
    assign lcd_data_oe = oe_q;
    assign done        = done_q;

    // R5: write enable is only active inside chip select
    a_r5_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        we_act_q |-> !cs_n_q);

    // R4: write enable activates only after chip select has been low
    a_r4_we_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_act_q) |-> $past(!cs_n_q));

    // R10: done marks the clock where chip select rises
    a_r10_done_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $rose(cs_n_q));

    // R7: data drivers release together with chip select
    a_r7_oe_release_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_q) |-> $rose(cs_n_q));

endmodule

// File: rtl/lcd_wcyc_seq.sv
module lcd_wcyc_seq
    import lcd_wcyc_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_is_cmd,
    input  logic [DW-1:0] req_data,
    input  logic [TW-1:0] cfg_cs_setup,
    input  logic [TW-1:0] cfg_wr_setup,
    input  logic [TW-1:0] cfg_wr_active,
    input  logic [TW-1:0] cfg_wr_hold,
    input  logic          we_invert,
    output logic          lcd_rs,
    output logic          lcd_cs_n,
    output logic          lcd_we,
    output logic [DW-1:0] lcd_data,
    output logic          lcd_data_oe,
    output logic          done
);

    wcyc_state_t   state;
    wcyc_state_t   state_nxt;
    logic          accept;
    logic          load;
    logic [TW-1:0] load_val;
    logic          expired;

    lcd_wcyc_fsm #(.TW(TW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .cfg_cs_setup (cfg_cs_setup),
        .cfg_wr_setup (cfg_wr_setup),
        .cfg_wr_active(cfg_wr_active),
        .cfg_wr_hold  (cfg_wr_hold),
        .expired      (expired),
        .state        (state),
        .state_nxt    (state_nxt),
        .ready        (req_ready),
        .accept       (accept),
        .load         (load),
        .load_val     (load_val)
    );

    lcd_wcyc_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    lcd_wcyc_pins #(.DW(DW)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .req_is_cmd (req_is_cmd),
        .req_data   (req_data),
        .state      (state),
        .state_nxt  (state_nxt),
        .expired    (expired),
        .we_invert  (we_invert),
        .lcd_rs     (lcd_rs),
        .lcd_cs_n   (lcd_cs_n),
        .lcd_we     (lcd_we),
        .lcd_data   (lcd_data),
        .lcd_data_oe(lcd_data_oe),
        .done       (done)
    );

    // R2: select line and word are frozen while busy
    a_r2_bus_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> ($stable(lcd_rs) && $stable(lcd_data)));

endmodule

// File: tb/tb_lcd_wcyc_seq.sv
module tb_lcd_wcyc_seq;

    localparam int DW = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_cmd = 1'b0;
    logic [DW-1:0] req_data = '0;
    logic [TW-1:0] cfg_cs_setup = 8'd0;
    logic [TW-1:0] cfg_wr_setup = 8'd0;
    logic [TW-1:0] cfg_wr_active = 8'd1;
    logic [TW-1:0] cfg_wr_hold = 8'd0;
    logic          we_invert = 1'b0;
    logic          lcd_rs, lcd_cs_n, lcd_we, lcd_data_oe, done;
    logic [DW-1:0] lcd_data;

    always #4 clk = ~clk;   // 125 MHz

    lcd_wcyc_seq #(.DW(DW), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_is_cmd(req_is_cmd), .req_data(req_data),
        .cfg_cs_setup(cfg_cs_setup), .cfg_wr_setup(cfg_wr_setup),
        .cfg_wr_active(cfg_wr_active), .cfg_wr_hold(cfg_wr_hold),
        .we_invert(we_invert), .lcd_rs(lcd_rs), .lcd_cs_n(lcd_cs_n),
        .lcd_we(lcd_we), .lcd_data(lcd_data), .lcd_data_oe(lcd_data_oe),
        .done(done)
    );

    typedef struct {
        logic          rs;
        logic [DW-1:0] data;
        int            cs, ws, wa, wh;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
        end
    endtask

    // driver: called at posedge+1
    task automatic send(input logic rs, input logic [DW-1:0] d,
                        input int cs, input int ws, input int wa, input int wh);
        item_t it;
        it.rs = rs; it.data = d; it.cs = cs; it.ws = ws; it.wa = wa; it.wh = wh;
        exp_q.push_back(it);
        req_is_cmd    = rs;
        req_data      = d;
        cfg_cs_setup  = TW'(cs);
        cfg_wr_setup  = TW'(ws);
        cfg_wr_active = TW'(wa);
        cfg_wr_hold   = TW'(wh);
        req_valid     = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        // R8: scramble the timing inputs during the cycle in progress
        cfg_cs_setup  = ~cfg_cs_setup;
        cfg_wr_setup  = cfg_wr_setup + 8'd5;
        cfg_wr_active = ~cfg_wr_active;
        cfg_wr_hold   = cfg_wr_hold + 8'd7;
        req_data      = ~req_data;
        req_is_cmd    = ~req_is_cmd;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    // monitor / scoreboard
    typedef enum {M_IDLE, M_ADDR, M_WS, M_WA, M_WH} mph_t;
    mph_t          ph = M_IDLE;
    int            n_addr, n_ws, n_wa, n_wh;
    logic          last_rs = 1'b0;
    logic [DW-1:0] last_data = '0;
    logic          we_act;

    always @(negedge clk) begin
        if (rst_n) begin
            we_act = (lcd_we == we_invert);   // R9 active level
            case (ph)
                M_IDLE: begin
                    chk(lcd_cs_n == 1'b1, "R6 idle cs_n high", lcd_cs_n, 1);
                    chk(lcd_we == ~we_invert, "R9 idle we inactive level", lcd_we, ~we_invert);
                    chk(done == 1'b0, "R10 done single pulse", done, 0);
                    chk(lcd_data_oe == 1'b0, "R7 idle oe low", lcd_data_oe, 0);
                    chk(lcd_rs == last_rs, "R2 idle rs held", lcd_rs, last_rs);
                    chk(lcd_data == last_data, "R2 idle data held", lcd_data, last_data);
                end
                M_ADDR: begin
                    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
                    if (n_addr == 0) begin
                        chk(lcd_rs == cur.rs, "R2 rs captured", lcd_rs, cur.rs);
                        chk(lcd_data == cur.data, "R2 data captured", lcd_data, cur.data);
                        last_rs = cur.rs; last_data = cur.data;
                    end else begin
                        chk(lcd_rs == last_rs && lcd_data == last_data, "R2 bus held busy",
                            lcd_data, last_data);
                    end
                    if (lcd_cs_n) begin
                        n_addr++;
                    end else begin
                        chk(n_addr == cur.cs + 1, "R3 cs setup length", n_addr, cur.cs + 1);
                        chk(!we_act, "R4 we inactive at cs fall", we_act, 0);
                        ph = M_WS; n_ws = 1;
                    end
                end
                M_WS: begin
                    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
                    if (we_act) begin
                        chk(n_ws == cur.ws + 1, "R4 we setup length", n_ws, cur.ws + 1);
                        chk(lcd_data_oe == 1'b1, "R7 oe at we fall", lcd_data_oe, 1);
                        ph = M_WA; n_wa = 1;
                    end else begin
                        chk(!lcd_cs_n && !lcd_data_oe, "R7 oe low before we", lcd_data_oe, 0);
                        n_ws++;
                    end
                end
                M_WA: begin
                    chk(!req_ready, "R2 ready low while busy", req_ready, 0);
                    if (!we_act) begin
                        chk(n_wa == cur.wa + 1, "R5 we active length", n_wa, cur.wa + 1);
                        chk(lcd_cs_n == 1'b0, "R6 cs low after we rise", lcd_cs_n, 0);
                        ph = M_WH; n_wh = 1;
                    end else begin
                        chk(lcd_data_oe == 1'b1 && !lcd_cs_n, "R7 oe during we", lcd_data_oe, 1);
                        n_wa++;
                    end
                end
                M_WH: begin
                    if (lcd_cs_n) begin
                        chk(n_wh == cur.wh + 1, "R6 hold length", n_wh, cur.wh + 1);
                        chk(done == 1'b1, "R10 done at cs rise", done, 1);
                        chk(lcd_data_oe == 1'b0, "R7 oe off at cs rise", lcd_data_oe, 0);
                        if (req_valid)
                            chk(req_ready == 1'b1, "R11 ready with done", req_ready, 1);
                        ph = M_IDLE;
                    end else begin
                        chk(lcd_data_oe && !done && !we_act, "R7 oe during hold", lcd_data_oe, 1);
                        n_wh++;
                    end
                end
                default: ph = M_IDLE;
            endcase
            if (req_valid && req_ready) begin
                chk(ph == M_IDLE, "R2 accept only idle", ph, M_IDLE);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected accept", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    ph = M_ADDR; n_addr = 0;
                end
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(lcd_cs_n == 1'b1, "R1 reset cs_n", lcd_cs_n, 1);
        chk(lcd_we == 1'b1, "R1 reset we", lcd_we, 1);
        chk(lcd_data_oe == 1'b0, "R1 reset oe", lcd_data_oe, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);
        chk(lcd_cs_n && lcd_we && !done && req_ready, "R1 after reset idle", lcd_cs_n, 1);

        send(1'b0, 16'h1234, 0, 0, 1, 0);       // reset-default timing
        idle(12);
        send(1'b1, 16'hA5C3, 3, 2, 4, 1);
        idle(18);
        send(1'b0, 16'h0001, 0, 0, 0, 0);       // shortest cycle
        idle(10);
        // R11: back-to-back requests
        send(1'b1, 16'h1111, 2, 1, 0, 2);
        send(1'b0, 16'h2222, 0, 3, 1, 0);
        send(1'b1, 16'h3333, 1, 0, 2, 1);
        idle(15);
        // R9: inverted write enable
        we_invert = 1'b1;
        idle(2);
        send(1'b0, 16'h5555, 1, 1, 3, 1);
        send(1'b1, 16'h6666, 0, 0, 0, 0);
        idle(15);
        we_invert = 1'b0;
        idle(2);
        send(1'b0, 16'hBEEF, 6, 0, 2, 5);
        while (exp_q.size() != 0 || ph != M_IDLE) idle(1);
        idle(5);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule